// File: doc/BRIEF.md
# Application Zone Access and Erase Controller

This block guards three bit-addressed application zones of a serial secure memory: bits 176–431 (zone 1), 480–735 (zone 2) and 1024–1535 (zone 3). It watches the bit address and the stored value at that address as a host steps through memory. It reports whether the current bit may be read, written or erased. When a sequence of operations earns a whole-zone erase, it issues a one-cycle erase command with a zone index. The security-code check and the memory array sit outside the block: the validated flag comes in as an input, and the stored bit is supplied by the array.

Permissions are collected along the way. When the host addresses a zone's two control bits, the block latches per-zone write and read flags. A separate erase-key comparator sets per-zone erase flags after a full bit-by-bit key match. In the personalised mode, zone 2 can optionally be limited by a one-way erase budget held in 128 counter bits.

Each cycle carries at most one of three strobes. `visit` means the address was stepped onto. `cmp_strb` means the host bit is compared with the stored bit. `prog_strb` means a program operation, an erase when `prog_erase` is 1 and a write when it is 0.

Top module: `zac_top`

## Requirements
- R1: The block is in level 2 when `issuer_fuse` is 0 or `fuse_pin` is 0, and in level 1 otherwise.
- R2: A `visit` at bit 176, 480 or 1024 with `stored_bit`=1 sets the write flag of zone 1, 2 or 3. A `visit` at 177, 481 or 1025 sets that zone's read flag in the same way. A visit with `stored_bit`=0 sets nothing. The flags stay set until `rst_n` goes low, even if the control bit is later 0.
- R3: Inside a zone, `rd_ok` = read flag OR `sv`. `wr_ok` = `sv` in level 1, and `sv` AND the zone write flag in level 2. Outside the zones and the counter bits (768–895), `rd_ok` and `wr_ok` are 0.
- R4: In level 1 with `sv`=1, `er_ok` is 1 on every zone bit, and an erase there commands a whole-zone erase of that zone. In level 1 counter bits are writable with `sv` but never erasable.
- R5: An erase flag is set only by compare strobes over every bit of its key, in address order: 432–479 for zone 1, 736–767 for zone 2, 1536–1583 for zone 3. Every compare must match `host_bit` to `stored_bit`. A mismatch, or a `visit` inside the key range, voids the run.
- R6: In level 2, an erase at bit 480 commands a zone 1 erase only if `sv` and the zone 1 erase flag are set. An erase at bit 1584 commands a zone 3 erase only if `sv` and the zone 3 erase flag are set.
- R7: In level 2 with `cnt_en_fuse`=0, an erase at bit 768 commands a zone 2 erase only if `sv` and the zone 2 erase flag are set.
- R8: In level 2 with `cnt_en_fuse`=1, a counter bit is writable only when `sv`, the zone 2 erase flag and `stored_bit`=1 all hold. A write so accepted arms the block. An erase as the very next strobe then commands a zone 2 erase; any other strobe disarms it. An unarmed erase on a counter bit has `er_ok`=0, so a counter whose bits are all 0 grants no erase.
- R9: A `visit` at address 0 clears all three erase flags.
- R10: `zone_erase` is high for exactly the one cycle after an accepted erase strobe, with `zone_idx` 1, 2 or 3 naming the zone. `zone_idx` is 0 whenever `zone_erase` is low. No command is issued if any condition is missing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| addr | input | ADDR_W | Current bit address |
| stored_bit | input | 1 | Stored value at `addr` |
| visit | input | 1 | Address stepped onto `addr` |
| cmp_strb | input | 1 | Compare `host_bit` with `stored_bit` |
| host_bit | input | 1 | Host data for compare |
| prog_strb | input | 1 | Program operation at `addr` |
| prog_erase | input | 1 | 1 = erase, 0 = write |
| sv | input | 1 | Security code validated |
| issuer_fuse | input | 1 | Issuer fuse, 0 = blown |
| fuse_pin | input | 1 | Fuse pin level |
| cnt_en_fuse | input | 1 | Zone 2 erase budget enable |
| rd_ok | output | 1 | Read permitted at `addr` |
| wr_ok | output | 1 | Write permitted at `addr` |
| er_ok | output | 1 | Erase at `addr` is accepted |
| zone_erase | output | 1 | Whole-zone erase command pulse |
| zone_idx | output | 2 | Zone of the command, 0 when idle |

## Verification
The bench sweeps every address against every combination of fuse pin, issuer fuse, counter fuse and validated flag. It runs the sweep with no flags, with all permission flags, and with all erase flags, so a wrong zone boundary or a swapped level decode shows up as a permit on the wrong bit. Other tests target ordering:
- Bit 480 sits inside zone 2 yet triggers a zone 1 erase in level 2. A design that mixes these up erases the wrong zone.
- A single bad key bit, or a read step in the middle of a key, must void the match. A design that only checks the last bit would grant the erase anyway.
- A counter write on an already-zero bit must refuse the erase, and an arm must be spent by one erase. Getting either wrong lets the erase budget be exceeded.
- Returning to address 0 must drop the erase flags. A design that keeps them would allow a replayed erase.

// File: rtl/zac_pkg.sv
package zac_pkg;

    localparam int unsigned NZONE = 3;

    // zone and key ranges, index 1..3 is the zone number
    localparam int unsigned Z_LO [1:3] = '{176, 480, 1024};
    localparam int unsigned Z_HI [1:3] = '{431, 735, 1535};
    localparam int unsigned K_LO [1:3] = '{432, 736, 1536};
    localparam int unsigned K_HI [1:3] = '{479, 767, 1583};

    // level-2 erase trigger bits
    localparam int unsigned TRIG_Z1 = 480;
    localparam int unsigned TRIG_Z2 = 768;
    localparam int unsigned TRIG_Z3 = 1584;

    // zone 2 erase budget bits
    localparam int unsigned CTR_LO = 768;
    localparam int unsigned CTR_HI = 895;

    typedef logic [1:0] zidx_t;

    function automatic zidx_t zone_of(input int unsigned a);
        zidx_t z;
        z = '0;
        for (int k = 1; k <= int'(NZONE); k++)
            if (a >= Z_LO[k] && a <= Z_HI[k]) z = zidx_t'(k);
        return z;
    endfunction

    function automatic zidx_t key_of(input int unsigned a);
        zidx_t z;
        z = '0;
        for (int k = 1; k <= int'(NZONE); k++)
            if (a >= K_LO[k] && a <= K_HI[k]) z = zidx_t'(k);
        return z;
    endfunction

    function automatic logic in_ctr(input int unsigned a);
        return (a >= CTR_LO) && (a <= CTR_HI);
    endfunction

endpackage

// File: rtl/zac_flags.sv
module zac_flags
    import zac_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              visit,
    input  logic [ADDR_W-1:0] addr,
    input  logic              stored_bit,
    output logic [3:1]        wp,
    output logic [3:1]        rp
);

    typedef struct packed {
        logic [3:1] wp;
        logic [3:1] rp;
    } flags_t;

    flags_t     st_d, st_q;
    logic [3:1] hit_w, hit_r;

    // write control bit is the first zone bit, read control bit the second
    for (genvar k = 1; k <= NZONE; k++) begin : g_ctl
        assign hit_w[k] = visit && stored_bit && (32'(addr) == Z_LO[k]);
        assign hit_r[k] = visit && stored_bit && (32'(addr) == Z_LO[k] + 1);
    end

    always_comb begin
        st_d    = st_q;
        st_d.wp = st_q.wp | hit_w;
        st_d.rp = st_q.rp | hit_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wp = st_q.wp;
    assign rp = st_q.rp;

    // R2: once set, a permission flag never drops before reset
    p_sticky_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|{st_q.wp, st_q.rp}) |=>
            (({st_q.wp, st_q.rp} & $past({st_q.wp, st_q.rp})) == $past({st_q.wp, st_q.rp})));

    // R2: a flag rises only after a visit with a stored 1
    p_rise_needs_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(visit && stored_bit) |=> ({st_q.wp, st_q.rp} == $past({st_q.wp, st_q.rp})));

endmodule

// File: rtl/zac_keymatch.sv
module zac_keymatch
    import zac_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              visit,
    input  logic              cmp_strb,
    input  logic              prog_strb,
    input  logic [ADDR_W-1:0] addr,
    input  logic              stored_bit,
    input  logic              host_bit,
    input  logic              arm_set,
    output logic [3:1]        ef,
    output logic              armed
);

    typedef struct packed {
        logic       run;
        logic [3:1] ef;
        logic       arm;
    } km_t;

    km_t         st_d, st_q;
    int unsigned a;
    zidx_t       kz;
    logic        is_first, is_last;

    assign a  = 32'(addr);
    assign kz = key_of(a);

    always_comb begin
        is_first = 1'b0;
        is_last  = 1'b0;
        for (int k = 1; k <= int'(NZONE); k++) begin
            if (kz == zidx_t'(k) && a == K_LO[k]) is_first = 1'b1;
            if (kz == zidx_t'(k) && a == K_HI[k]) is_last  = 1'b1;
        end
    end

    always_comb begin
        logic run_n;
        st_d  = st_q;
        run_n = 1'b0;
        if (cmp_strb) begin
            if (kz != 2'd0) begin
                run_n = (host_bit == stored_bit) && (is_first || st_q.run);
                if (is_last) begin
                    if (run_n) st_d.ef[kz] = 1'b1;
                    st_d.run = 1'b0;
                end else begin
                    st_d.run = run_n;
                end
            end else begin
                st_d.run = 1'b0;
            end
        end
        if (visit) begin
            if (kz != 2'd0) st_d.run = 1'b0;
            if (a == 0) begin
                st_d.ef  = '0;
                st_d.run = 1'b0;
            end
        end
        // any strobe spends the arm; only an accepted budget write re-arms
        if (visit || cmp_strb || prog_strb) st_d.arm = arm_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ef    = st_q.ef;
    assign armed = st_q.arm;

    // R9: returning to address 0 drops every erase flag
    p_clear_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (visit && addr == '0) |=> (st_q.ef == 3'b000));

    // R5: an erase flag rises only on a compare of a key's final bit
    p_rise_on_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_strb && is_last) |=> ((st_q.ef & ~$past(st_q.ef)) == 3'b000));

endmodule

// File: rtl/zac_policy.sv
module zac_policy
    import zac_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              stored_bit,
    input  logic              sv,
    input  logic              l2,
    input  logic              cnt_en,
    input  logic [3:1]        wp,
    input  logic [3:1]        rp,
    input  logic [3:1]        ef,
    input  logic              armed,
    input  logic              prog_strb,
    input  logic              prog_erase,
    output logic              rd_ok,
    output logic              wr_ok,
    output logic              er_ok,
    output zidx_t             er_zone,
    output logic              arm_set
);

    int unsigned a;
    zidx_t       z;
    logic        c;

    assign a = 32'(addr);
    assign z = zone_of(a);
    assign c = in_ctr(a);

    always_comb begin
        rd_ok   = 1'b0;
        wr_ok   = 1'b0;
        er_ok   = 1'b0;
        er_zone = 2'd0;
        if (z != 2'd0) begin
            rd_ok = rp[z] | sv;
            wr_ok = l2 ? (sv & wp[z]) : sv;
        end else if (c) begin
            wr_ok = l2 ? (cnt_en & sv & ef[2] & stored_bit) : sv;
        end
        if (!l2) begin
            if (z != 2'd0 && sv) begin
                er_ok   = 1'b1;
                er_zone = z;
            end
        end else if (sv) begin
            if (a == TRIG_Z1 && ef[1]) begin
                er_ok   = 1'b1;
                er_zone = 2'd1;
            end else if (a == TRIG_Z3 && ef[3]) begin
                er_ok   = 1'b1;
                er_zone = 2'd3;
            end else if (!cnt_en && a == TRIG_Z2 && ef[2]) begin
                er_ok   = 1'b1;
                er_zone = 2'd2;
            end else if (cnt_en && c && ef[2] && armed) begin
                er_ok   = 1'b1;
                er_zone = 2'd2;
            end
        end
        arm_set = prog_strb & ~prog_erase & wr_ok & c & l2 & cnt_en;
    end

endmodule

// File: rtl/zac_top.sv
module zac_top
    import zac_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              stored_bit,
    input  logic              visit,
    input  logic              cmp_strb,
    input  logic              host_bit,
    input  logic              prog_strb,
    input  logic              prog_erase,
    input  logic              sv,
    input  logic              issuer_fuse,
    input  logic              fuse_pin,
    input  logic              cnt_en_fuse,
    output logic              rd_ok,
    output logic              wr_ok,
    output logic              er_ok,
    output logic              zone_erase,
    output logic [1:0]        zone_idx
);

    typedef struct packed {
        logic  pulse;
        zidx_t idx;
    } cmd_t;

    logic       l2;
    logic [3:1] wp, rp, ef;
    logic       armed, arm_set;
    zidx_t      er_zone;
    cmd_t       cmd_d, cmd_q;

    assign l2 = ~issuer_fuse | ~fuse_pin;

    zac_flags #(.ADDR_W(ADDR_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .visit(visit), .addr(addr),
        .stored_bit(stored_bit), .wp(wp), .rp(rp)
    );

    zac_keymatch #(.ADDR_W(ADDR_W)) u_keymatch (
        .clk(clk), .rst_n(rst_n), .visit(visit), .cmp_strb(cmp_strb),
        .prog_strb(prog_strb), .addr(addr), .stored_bit(stored_bit),
        .host_bit(host_bit), .arm_set(arm_set), .ef(ef), .armed(armed)
    );

    zac_policy #(.ADDR_W(ADDR_W)) u_policy (
        .addr(addr), .stored_bit(stored_bit), .sv(sv), .l2(l2),
        .cnt_en(cnt_en_fuse), .wp(wp), .rp(rp), .ef(ef), .armed(armed),
        .prog_strb(prog_strb), .prog_erase(prog_erase), .rd_ok(rd_ok),
        .wr_ok(wr_ok), .er_ok(er_ok), .er_zone(er_zone), .arm_set(arm_set)
    );

    always_comb begin
        cmd_d = '0;
        if (prog_strb && prog_erase && er_ok) begin
            cmd_d.pulse = 1'b1;
            cmd_d.idx   = er_zone;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    assign zone_erase = cmd_q.pulse;
    assign zone_idx   = cmd_q.idx;

    // R10: a command follows an accepted erase strobe
    p_cmd_needs_permit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        zone_erase |-> $past(prog_strb && prog_erase && er_ok));

    // R10: index is zero while idle and names a zone while active
    p_idx_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !zone_erase |-> (zone_idx == 2'd0));
    p_idx_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        zone_erase |-> (zone_idx != 2'd0));

    // R3: in level 2 a zone write needs the latched write flag and sv
    p_l2_write_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (l2 && wr_ok && zone_of(32'(addr)) != 2'd0) |-> (sv && wp[zone_of(32'(addr))]));

    // R8: with the budget on, a counter bit is erasable only when armed
    p_ctr_erase_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (l2 && cnt_en_fuse && in_ctr(32'(addr)) && er_ok) |-> armed);

endmodule

// File: tb/zac_top_bench.sv
module zac_top_bench;
    import zac_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [10:0] addr = '0;
    logic       stored_bit = 1'b0, visit = 1'b0, cmp_strb = 1'b0, host_bit = 1'b0;
    logic       prog_strb = 1'b0, prog_erase = 1'b0, sv = 1'b0;
    logic       issuer_fuse = 1'b1, fuse_pin = 1'b1, cnt_en_fuse = 1'b0;
    logic       rd_ok, wr_ok, er_ok, zone_erase;
    logic [1:0] zone_idx;

    int vectors = 0, misses = 0;
    logic [3:1] bwp = '0, brp = '0, bef = '0;

    always #5 clk = ~clk;

    zac_top u_zac_top (
        .clk(clk), .rst_n(rst_n), .addr(addr), .stored_bit(stored_bit),
        .visit(visit), .cmp_strb(cmp_strb), .host_bit(host_bit),
        .prog_strb(prog_strb), .prog_erase(prog_erase), .sv(sv),
        .issuer_fuse(issuer_fuse), .fuse_pin(fuse_pin), .cnt_en_fuse(cnt_en_fuse),
        .rd_ok(rd_ok), .wr_ok(wr_ok), .er_ok(er_ok),
        .zone_erase(zone_erase), .zone_idx(zone_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s addr=%0d actual=%0h expected=%0h", req, addr, act, exp);
        end
    endtask

    // expected {rd,wr,er} with no arm pending, from R1, R3, R4, R6, R7, R8
    function automatic logic [2:0] model(input int a, input logic st);
        logic l2, rd, wr, er;
        int z;
        l2 = !issuer_fuse || !fuse_pin;
        z = 0; rd = 0; wr = 0; er = 0;
        if (a >= 176 && a <= 431) z = 1;
        if (a >= 480 && a <= 735) z = 2;
        if (a >= 1024 && a <= 1535) z = 3;
        if (z != 0) begin
            rd = brp[z] || sv;
            wr = l2 ? (sv && bwp[z]) : sv;
        end else if (a >= 768 && a <= 895) begin
            wr = l2 ? (cnt_en_fuse && sv && bef[2] && st) : sv;
        end
        if (!l2) er = (z != 0) && sv;
        else if (sv) er = (a == 480 && bef[1]) || (a == 1584 && bef[3]) ||
                          (a == 768 && !cnt_en_fuse && bef[2]);
        return {rd, wr, er};
    endfunction

    task automatic sweep_all(input string req);
        for (int cfg = 0; cfg < 16; cfg++) begin
            {sv, issuer_fuse, fuse_pin, cnt_en_fuse} = 4'(cfg);
            for (int a = 0; a < 1600; a++) begin
                for (int s = 0; s < 2; s++) begin
                    addr = 11'(a); stored_bit = s[0];
                    #1;
                    chk(req, {29'd0, rd_ok, wr_ok, er_ok}, {29'd0, model(a, s[0])});
                end
            end
        end
    endtask

    // strobe kinds: 0 visit, 1 compare, 2 write, 3 erase
    task automatic op(input int kind, input int a, input logic st, input logic hb);
        addr = 11'(a); stored_bit = st; host_bit = hb;
        visit = (kind == 0); cmp_strb = (kind == 1);
        prog_strb = (kind >= 2); prog_erase = (kind == 3);
        @(posedge clk); #2;
        visit = 0; cmp_strb = 0; prog_strb = 0; prog_erase = 0;
    endtask

    function automatic logic keybit(input int a);
        return logic'(a[0] ^ a[3]);
    endfunction

    task automatic match_key(input int lo, input int hi, input int bad, input int brk);
        for (int a = lo; a <= hi; a++) begin
            if (a == brk) op(0, a, keybit(a), 1'b0);
            else op(1, a, keybit(a), (a == bad) ? ~keybit(a) : keybit(a));
        end
    endtask

    task automatic erase_at(input string req, input int a, input logic st, input int exp_idx);
        addr = 11'(a); stored_bit = st; prog_strb = 1; prog_erase = 1;
        #1;
        chk(req, {31'd0, er_ok}, {31'd0, exp_idx != 0});
        @(posedge clk); #2;
        prog_strb = 0; prog_erase = 0;
        chk(req, {31'd0, zone_erase}, {31'd0, exp_idx != 0});
        chk(req, {30'd0, zone_idx}, 32'(exp_idx));
        @(posedge clk); #2;
        chk(req, {31'd0, zone_erase}, 32'd0);
    endtask

    task automatic write_at(input string req, input int a, input logic st, input logic exp_wr);
        addr = 11'(a); stored_bit = st; prog_strb = 1; prog_erase = 0;
        #1;
        chk(req, {31'd0, wr_ok}, {31'd0, exp_wr});
        @(posedge clk); #2;
        prog_strb = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        chk("R10 reset pulse", {31'd0, zone_erase}, 32'd0);
        chk("R10 reset idx", {30'd0, zone_idx}, 32'd0);

        // R1 R3 R4: all permits with no flags
        sweep_all("R3 sweep no flags");

        // R2: latching of permission flags in level 2
        issuer_fuse = 0; fuse_pin = 1; sv = 1; cnt_en_fuse = 0;
        op(0, 176, 1'b0, 1'b0);
        addr = 200; #1; chk("R2 zero control bit", {31'd0, wr_ok}, 32'd0);
        op(0, 176, 1'b1, 1'b0);
        addr = 200; #1; chk("R2 write flag set", {31'd0, wr_ok}, 32'd1);
        op(0, 176, 1'b0, 1'b0);
        addr = 200; #1; chk("R2 write flag sticky", {31'd0, wr_ok}, 32'd1);
        sv = 0;
        op(0, 481, 1'b1, 1'b0);
        addr = 500;  #1; chk("R2 read flag zone2", {31'd0, rd_ok}, 32'd1);
        addr = 1100; #1; chk("R2 zone3 untouched", {31'd0, rd_ok}, 32'd0);
        addr = 300;  #1; chk("R2 zone1 read untouched", {31'd0, rd_ok}, 32'd0);
        op(0, 177, 1'b1, 1'b0); op(0, 480, 1'b1, 1'b0);
        op(0, 1024, 1'b1, 1'b0); op(0, 1025, 1'b1, 1'b0);
        bwp = 3'b111; brp = 3'b111;
        sweep_all("R3 sweep flags set");

        // R5 R6 R9: zone 1 key and trigger bit 480
        issuer_fuse = 0; fuse_pin = 1; sv = 1; cnt_en_fuse = 0;
        match_key(432, 479, -1, -1);
        erase_at("R6 zone1 erase", 480, 1'b1, 1);
        erase_at("R6 flag persists", 480, 1'b1, 1);
        sv = 0; erase_at("R6 needs sv", 480, 1'b1, 0); sv = 1;
        op(0, 0, 1'b1, 1'b0);
        erase_at("R9 cleared at zero", 480, 1'b1, 0);
        match_key(432, 479, 450, -1);
        erase_at("R5 bad key bit", 480, 1'b1, 0);
        match_key(432, 479, -1, 456);
        erase_at("R5 visit breaks run", 480, 1'b1, 0);

        // R1 R6: zone 3 via fuse pin low with issuer fuse intact
        op(0, 0, 1'b1, 1'b0);
        issuer_fuse = 1; fuse_pin = 0;
        match_key(1536, 1583, -1, -1);
        erase_at("R6 zone3 erase", 1584, 1'b0, 3);
        erase_at("R6 zone3 not at 480", 480, 1'b0, 0);

        // R7: zone 2 without budget
        op(0, 0, 1'b1, 1'b0);
        issuer_fuse = 0; fuse_pin = 1;
        match_key(736, 767, -1, -1);
        erase_at("R7 zone2 erase", 768, 1'b1, 2);
        erase_at("R7 other counter bit", 800, 1'b1, 0);

        // R3 R6 R7: sweep with all erase flags
        match_key(432, 479, -1, -1);
        match_key(1536, 1583, -1, -1);
        bef = 3'b111;
        sweep_all("R3 sweep erase flags");

        // R8: budgeted zone 2 erase
        issuer_fuse = 0; fuse_pin = 1; sv = 1; cnt_en_fuse = 1;
        erase_at("R8 unarmed erase at 768", 768, 1'b1, 0);
        write_at("R8 write on one bit", 800, 1'b1, 1'b1);
        erase_at("R8 armed erase", 800, 1'b0, 2);
        erase_at("R8 arm spent", 800, 1'b0, 0);
        write_at("R8 write on zero bit", 801, 1'b0, 1'b0);
        erase_at("R8 exhausted bit", 801, 1'b0, 0);
        write_at("R8 rearm", 802, 1'b1, 1'b1);
        op(0, 802, 1'b0, 1'b0);
        erase_at("R8 intervening strobe", 802, 1'b0, 0);
        op(0, 0, 1'b1, 1'b0);
        write_at("R8 needs erase flag", 803, 1'b1, 1'b0);

        // R4: level 1 zone erase on any zone bit
        issuer_fuse = 1; fuse_pin = 1; sv = 1;
        erase_at("R4 zone1 body", 300, 1'b0, 1);
        erase_at("R4 zone2 at 480", 480, 1'b1, 2);
        erase_at("R4 zone3 body", 1200, 1'b0, 3);
        erase_at("R4 counter never erased", 800, 1'b0, 0);
        sv = 0;
        erase_at("R4 needs sv", 600, 1'b0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule